// File: doc/BRIEF.md
# Power domain power-up sequencer

This block brings a single power domain from fully off to running. It holds the domain in reset, asks the external power switch for power, turns on the domain clock, waits for the rails to settle, releases the isolation clamps, waits again, and only then lets the domain out of reset. The power switch, clock gate and clamp logic are outside the block. Each answers a request with an acknowledge or an error line.

A request is a one-cycle start pulse with a domain index. An index at or above the configured domain count is refused at once and nothing else happens. If the requested domain already reports power, the power step is skipped and no power request is sent. Every wait for an answer is limited by a timeout, and a timeout counts as that step's failure. When a step fails, the block undoes only the steps that had completed, newest first. It then pulses an error flag with a code. On success it pulses a done flag and leaves the clock on and the reset released.

Top module: `pd_seq`

## Requirements
- R1: The cycle after an accepted start, `dom_rst_o` is high and `clk_en_o` is low. The power request comes no earlier than the following cycle.
- R2: If the domain's bit in `pwr_state_i` is 0, `pwr_on_o` pulses for one cycle with `pwr_id_o` equal to the index. The block then waits for `pwr_ack_i`, which is accepted in the cycle it is high.
- R3: If the domain's bit in `pwr_state_i` is already 1, no `pwr_on_o` pulse is issued and the clock step follows directly.
- R4: `clk_en_o` rises only after power is confirmed. After `clk_ack_i`, the block waits exactly `CLK_MHZ*SETTLE_US` cycles and then pulses `unclamp_o` for one cycle.
- R5: After `clamp_ack_i`, the block waits another `CLK_MHZ*SETTLE_US` cycles. It then drops `dom_rst_o` and pulses `done_o`, and `clk_en_o` stays high afterwards.
- R6: `pwr_err_i` during the power wait ends the sequence with error code 2. No undo strobe is issued.
- R7: A clock failure (`clk_err_i` or timeout) drops `clk_en_o`, then pulses `pwr_off_o` once, then signals error code 3.
- R8: A clamp failure drops `clk_en_o`, then pulses `pwr_off_o` in a later cycle, then signals error code 4.
- R9: A start with an index of `NUM_DOMAINS` or above gives error code 1 in the next cycle. No strobe is issued and no level output changes.
- R10: A wait that gets neither acknowledge nor error within `ACK_TIMEOUT` cycles fails as that step's error.
- R11: A start while a sequence is running is ignored, and the running sequence keeps its index.
- R12: `done_o` and `err_o` are one-cycle pulses. `err_code_o` is valid while `err_o` is high (codes: 1 bad index, 2 power, 3 clock, 4 clamp).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to power up a domain |
| dom_id_i | input | ID_W | Index of the domain to power up |
| pwr_state_i | input | NUM_DOMAINS | Present power status of each domain |
| pwr_ack_i | input | 1 | Power switch confirms power on |
| pwr_err_i | input | 1 | Power switch reports failure |
| clk_ack_i | input | 1 | Clock gate confirms the clock runs |
| clk_err_i | input | 1 | Clock gate reports failure |
| clamp_ack_i | input | 1 | Clamp logic confirms release |
| clamp_err_i | input | 1 | Clamp logic reports failure |
| dom_rst_o | output | 1 | Domain reset, high = held in reset |
| pwr_on_o | output | 1 | Power-on request strobe |
| pwr_off_o | output | 1 | Power-off strobe used when undoing |
| pwr_id_o | output | ID_W | Index of the domain being sequenced |
| clk_en_o | output | 1 | Domain clock enable level |
| unclamp_o | output | 1 | Clamp release strobe |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Failure pulse |
| err_code_o | output | 3 | Failure cause, valid with err_o |

## Verification
The bench checks every step boundary against a per-cycle reference timeline. An off-by-one settle counter would move the clamp strobe or the done pulse by one cycle. The already-powered case catches a design that sends a redundant power toggle. Each failure point has its own check, because an unwind that runs too much (a power-off after a failed power-on) or in the wrong order (power off before the clock drops) shows up in the strobe pattern. Out-of-range indices exactly at the domain count and at the top of the index range catch an off-by-one range test. A start injected mid-sequence with a bad index would, if accepted, corrupt the latched index or raise an error.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST,
    ST_PWR_REQ,
    ST_PWR_WAIT,
    ST_CLK_WAIT,
    ST_SETTLE_A,
    ST_CLAMP_REQ,
    ST_CLAMP_WAIT,
    ST_SETTLE_B,
    ST_FINISH,
    ST_UNDO_CLK,
    ST_UNDO_PWR,
    ST_FAIL
  } seq_st_e;

  typedef enum logic [2:0] {
    E_NONE   = 3'd0,
    E_BAD_ID = 3'd1,
    E_PWR    = 3'd2,
    E_CLK    = 3'd3,
    E_CLAMP  = 3'd4
  } err_e;

endpackage

// File: rtl/pd_seq_timer.sv
module pd_seq_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = val_i;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pd_seq_idsel.sv
module pd_seq_idsel #(
  parameter int ID_W        = 5,
  parameter int NUM_DOMAINS = 25
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ID_W-1:0]        dom_id_i,
  input  logic                   id_ld_i,
  input  logic [NUM_DOMAINS-1:0] pwr_state_i,
  output logic                   id_ok_o,
  output logic [ID_W-1:0]        id_q_o,
  output logic                   already_o
);

  localparam int ID_SPAN = 1 << ID_W;

  logic [ID_SPAN-1:0] state_pad;
  logic [ID_W-1:0]    id_q;

  assign state_pad = ID_SPAN'(pwr_state_i);
  assign id_ok_o   = (int'(dom_id_i) < NUM_DOMAINS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= '0;
    else if (id_ld_i) id_q <= dom_id_i;
  end

  assign id_q_o    = id_q;
  assign already_o = state_pad[id_q];

endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_seq_pkg::*;
#(
  parameter int ID_W       = 5,
  parameter int CNT_W      = 10,
  parameter int SETTLE_CYC = 1000,
  parameter int ACK_TO     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             id_ok_i,
  input  logic             already_i,
  input  logic [ID_W-1:0]  id_q_i,
  input  logic             tz_i,
  input  logic             pwr_ack_i,
  input  logic             pwr_err_i,
  input  logic             clk_ack_i,
  input  logic             clk_err_i,
  input  logic             clamp_ack_i,
  input  logic             clamp_err_i,
  output logic             id_ld_o,
  output logic             tload_o,
  output logic [CNT_W-1:0] tval_o,
  output logic             dom_rst_o,
  output logic             pwr_on_o,
  output logic             pwr_off_o,
  output logic [ID_W-1:0]  pwr_id_o,
  output logic             clk_en_o,
  output logic             unclamp_o,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       err_code_o
);

  localparam logic [CNT_W-1:0] ACK_LOAD    = CNT_W'(ACK_TO - 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);

  seq_st_e st_q, st_d;
  logic    rst_hold_q, clk_en_q;
  err_e    code_q, code_d;
  logic    set_rst, clr_rst, set_clk, clr_clk, code_ld;

  always_comb begin
    st_d    = st_q;
    id_ld_o = 1'b0;
    tload_o = 1'b0;
    tval_o  = ACK_LOAD;
    set_rst = 1'b0;
    clr_rst = 1'b0;
    set_clk = 1'b0;
    clr_clk = 1'b0;
    code_ld = 1'b0;
    code_d  = code_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (id_ok_i) begin
            st_d    = ST_RST;
            id_ld_o = 1'b1;
            set_rst = 1'b1;
            clr_clk = 1'b1;
          end else begin
            st_d    = ST_FAIL;
            code_ld = 1'b1;
            code_d  = E_BAD_ID;
          end
        end
      end
      ST_RST: st_d = ST_PWR_REQ;
      ST_PWR_REQ: begin
        tload_o = 1'b1;
        if (already_i) begin
          st_d    = ST_CLK_WAIT;
          set_clk = 1'b1;
        end else begin
          st_d = ST_PWR_WAIT;
        end
      end
      ST_PWR_WAIT: begin
        if (pwr_ack_i) begin
          st_d    = ST_CLK_WAIT;
          set_clk = 1'b1;
          tload_o = 1'b1;
        end else if (pwr_err_i || tz_i) begin
          st_d    = ST_FAIL;
          code_ld = 1'b1;
          code_d  = E_PWR;
        end
      end
      ST_CLK_WAIT: begin
        if (clk_ack_i) begin
          st_d    = ST_SETTLE_A;
          tload_o = 1'b1;
          tval_o  = SETTLE_LOAD;
        end else if (clk_err_i || tz_i) begin
          st_d    = ST_UNDO_PWR;
          clr_clk = 1'b1;
          code_ld = 1'b1;
          code_d  = E_CLK;
        end
      end
      ST_SETTLE_A: if (tz_i) st_d = ST_CLAMP_REQ;
      ST_CLAMP_REQ: begin
        st_d    = ST_CLAMP_WAIT;
        tload_o = 1'b1;
      end
      ST_CLAMP_WAIT: begin
        if (clamp_ack_i) begin
          st_d    = ST_SETTLE_B;
          tload_o = 1'b1;
          tval_o  = SETTLE_LOAD;
        end else if (clamp_err_i || tz_i) begin
          st_d    = ST_UNDO_CLK;
          clr_clk = 1'b1;
          code_ld = 1'b1;
          code_d  = E_CLAMP;
        end
      end
      ST_SETTLE_B: begin
        if (tz_i) begin
          st_d    = ST_FINISH;
          clr_rst = 1'b1;
        end
      end
      ST_FINISH:   st_d = ST_IDLE;
      ST_UNDO_CLK: st_d = ST_UNDO_PWR;
      ST_UNDO_PWR: st_d = ST_FAIL;
      ST_FAIL:     st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_hold_q <= 1'b0;
    else if (set_rst || clr_rst) rst_hold_q <= set_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_en_q <= 1'b0;
    else if (set_clk || clr_clk) clk_en_q <= set_clk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= E_NONE;
    else if (code_ld) code_q <= code_d;
  end

  assign dom_rst_o  = rst_hold_q;
  assign clk_en_o   = clk_en_q;
  assign pwr_on_o   = (st_q == ST_PWR_REQ) && !already_i;
  assign pwr_off_o  = (st_q == ST_UNDO_PWR);
  assign unclamp_o  = (st_q == ST_CLAMP_REQ);
  assign done_o     = (st_q == ST_FINISH);
  assign err_o      = (st_q == ST_FAIL);
  assign err_code_o = code_q;
  assign pwr_id_o   = id_q_i;

  // R1
  pwr_under_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on_o |-> (dom_rst_o && !clk_en_o));

  // R4
  unclamp_clk_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unclamp_o |-> (clk_en_o && dom_rst_o));

  // R5
  done_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (clk_en_o && !dom_rst_o));

  // R7
  pwr_off_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_o |-> !clk_en_o);

  // R9
  bad_id_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_i && !id_ok_i) |=> (err_o && err_code_o == 3'd1));

  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && start_i) |=> $stable(pwr_id_o));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwr_on_o, pwr_off_o, unclamp_o, done_o, err_o}));

endmodule

// File: rtl/pd_seq.sv
module pd_seq #(
  parameter int ID_W        = 5,
  parameter int NUM_DOMAINS = 25,
  parameter int CLK_MHZ     = 100,
  parameter int SETTLE_US   = 10,
  parameter int ACK_TIMEOUT = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [ID_W-1:0]        dom_id_i,
  input  logic [NUM_DOMAINS-1:0] pwr_state_i,
  input  logic                   pwr_ack_i,
  input  logic                   pwr_err_i,
  input  logic                   clk_ack_i,
  input  logic                   clk_err_i,
  input  logic                   clamp_ack_i,
  input  logic                   clamp_err_i,
  output logic                   dom_rst_o,
  output logic                   pwr_on_o,
  output logic                   pwr_off_o,
  output logic [ID_W-1:0]        pwr_id_o,
  output logic                   clk_en_o,
  output logic                   unclamp_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [2:0]             err_code_o
);

  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int MAX_CNT    = (SETTLE_CYC > ACK_TIMEOUT) ? SETTLE_CYC : ACK_TIMEOUT;
  localparam int CNT_W      = $clog2(MAX_CNT + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             id_ok, already, id_ld, tload, tz;
  logic [ID_W-1:0]  id_q;
  logic [CNT_W-1:0] tval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pd_seq_idsel #(
    .ID_W(ID_W), .NUM_DOMAINS(NUM_DOMAINS)
  ) u_idsel (
    .clk(clk), .rst_n(rst_int_n), .dom_id_i(dom_id_i), .id_ld_i(id_ld),
    .pwr_state_i(pwr_state_i), .id_ok_o(id_ok), .id_q_o(id_q), .already_o(already)
  );

  pd_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .load_i(tload), .val_i(tval), .zero_o(tz)
  );

  pd_seq_fsm #(
    .ID_W(ID_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC), .ACK_TO(ACK_TIMEOUT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .id_ok_i(id_ok),
    .already_i(already), .id_q_i(id_q), .tz_i(tz),
    .pwr_ack_i(pwr_ack_i), .pwr_err_i(pwr_err_i),
    .clk_ack_i(clk_ack_i), .clk_err_i(clk_err_i),
    .clamp_ack_i(clamp_ack_i), .clamp_err_i(clamp_err_i),
    .id_ld_o(id_ld), .tload_o(tload), .tval_o(tval),
    .dom_rst_o(dom_rst_o), .pwr_on_o(pwr_on_o), .pwr_off_o(pwr_off_o),
    .pwr_id_o(pwr_id_o), .clk_en_o(clk_en_o), .unclamp_o(unclamp_o),
    .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
  );

endmodule

// File: tb/pd_seq_tb.sv
module pd_seq_tb;

  localparam int ID_W   = 5;
  localparam int NDOM   = 25;
  localparam int TO     = 32;
  localparam int SETTLE = 1000;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [ID_W-1:0] dom_id;
  logic [NDOM-1:0] pwr_state;
  logic pwr_ack, pwr_err, clk_ack, clk_err, clamp_ack, clamp_err;
  logic dom_rst, pwr_on, pwr_off, clk_en, unclamp, done, err;
  logic [ID_W-1:0] pwr_id;
  logic [2:0] err_code;

  always #5 clk = ~clk;

  pd_seq #(
    .ID_W(ID_W), .NUM_DOMAINS(NDOM), .CLK_MHZ(100), .SETTLE_US(10), .ACK_TIMEOUT(TO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dom_id_i(dom_id), .pwr_state_i(pwr_state),
    .pwr_ack_i(pwr_ack), .pwr_err_i(pwr_err), .clk_ack_i(clk_ack), .clk_err_i(clk_err),
    .clamp_ack_i(clamp_ack), .clamp_err_i(clamp_err),
    .dom_rst_o(dom_rst), .pwr_on_o(pwr_on), .pwr_off_o(pwr_off), .pwr_id_o(pwr_id),
    .clk_en_o(clk_en), .unclamp_o(unclamp), .done_o(done), .err_o(err), .err_code_o(err_code)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [6:0] exp_q[$];
  logic [2:0] ecode_q[$];
  string      tag_q[$];
  bit m_rst = 0, m_clk = 0;
  int p_lat, c_lat, u_lat;
  bit p_e, c_e, u_e;
  int pcnt = 0, ccnt = 0, ucnt = 0;
  bit clk_prev = 0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R12 watchdog: actual still running, expected finished");
    summary();
  end

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // expected vector order: rst, clk_en, pwr_on, pwr_off, unclamp, done, err
  task automatic push(bit r, bit c, bit pon, bit poff, bit unc, bit dn, bit er,
                      logic [2:0] code, string tag);
    exp_q.push_back({r, c, pon, poff, unc, dn, er});
    ecode_q.push_back(code);
    tag_q.push_back(tag);
  endtask

  task automatic tick();
    logic [6:0] ev, av;
    logic [2:0] ec;
    string tg;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      ev = exp_q.pop_front();
      ec = ecode_q.pop_front();
      tg = tag_q.pop_front();
    end else begin
      ev = {m_rst, m_clk, 5'b0};
      ec = 3'd0;
      tg = "R12";
    end
    av = {dom_rst, clk_en, pwr_on, pwr_off, unclamp, done, err};
    check(av == ev, tg, "outputs", int'(av), int'(ev));
    if (ev[0]) check(err_code == ec, tg, "err_code", int'(err_code), int'(ec));
    pwr_ack = 0; pwr_err = 0; clk_ack = 0; clk_err = 0; clamp_ack = 0; clamp_err = 0;
    if (pwr_on) pcnt = p_lat;
    else if (pcnt > 0) begin
      pcnt--;
      if (pcnt == 0) begin if (p_e) pwr_err = 1; else pwr_ack = 1; end
    end
    if (clk_en && !clk_prev) ccnt = c_lat;
    if (ccnt > 0) begin
      ccnt--;
      if (ccnt == 0) begin if (c_e) clk_err = 1; else clk_ack = 1; end
    end
    clk_prev = clk_en;
    if (unclamp) ucnt = u_lat;
    else if (ucnt > 0) begin
      ucnt--;
      if (ucnt == 0) begin if (u_e) clamp_err = 1; else clamp_ack = 1; end
    end
  endtask

  // Builds the expected per-cycle timeline of one request.
  task automatic plan(int id, bit already, int pl, bit pe, int cl, bit ce, int ul, bit ue);
    int n;
    if (id >= NDOM) begin
      push(m_rst, m_clk, 0, 0, 0, 0, 1, 3'd1, "R9");
      return;
    end
    m_rst = 1; m_clk = 0;
    push(1, 0, 0, 0, 0, 0, 0, 3'd0, "R1");
    push(1, 0, !already, 0, 0, 0, 0, 3'd0, already ? "R3" : "R2");
    if (!already) begin
      n = (pl == 0) ? TO : pl;
      for (int j = 0; j < n; j++) push(1, 0, 0, 0, 0, 0, 0, 3'd0, "R2");
      if (pl == 0 || pe) begin
        push(1, 0, 0, 0, 0, 0, 1, 3'd2, (pl == 0) ? "R10" : "R6");
        return;
      end
    end
    n = (cl == 0) ? TO : cl;
    for (int j = 0; j < n; j++) push(1, 1, 0, 0, 0, 0, 0, 3'd0, "R4");
    if (cl == 0 || ce) begin
      push(1, 0, 0, 1, 0, 0, 0, 3'd0, "R7");
      push(1, 0, 0, 0, 0, 0, 1, 3'd3, (cl == 0) ? "R10" : "R7");
      return;
    end
    m_clk = 1;
    for (int j = 0; j < SETTLE; j++) push(1, 1, 0, 0, 0, 0, 0, 3'd0, "R4");
    push(1, 1, 0, 0, 1, 0, 0, 3'd0, "R4");
    n = (ul == 0) ? TO : ul;
    for (int j = 0; j < n; j++) push(1, 1, 0, 0, 0, 0, 0, 3'd0, "R5");
    if (ul == 0 || ue) begin
      m_clk = 0;
      push(1, 0, 0, 0, 0, 0, 0, 3'd0, "R8");
      push(1, 0, 0, 1, 0, 0, 0, 3'd0, "R8");
      push(1, 0, 0, 0, 0, 0, 1, 3'd4, (ul == 0) ? "R10" : "R8");
      return;
    end
    for (int j = 0; j < SETTLE; j++) push(1, 1, 0, 0, 0, 0, 0, 3'd0, "R5");
    m_rst = 0;
    push(0, 1, 0, 0, 0, 1, 0, 3'd0, "R5");
  endtask

  task automatic run(int id, int pl, bit pe, int cl, bit ce, int ul, bit ue, int busy_at);
    bit already;
    int k;
    already = (id < NDOM) ? pwr_state[id] : 1'b0;
    p_lat = pl; p_e = pe; c_lat = cl; c_e = ce; u_lat = ul; u_e = ue;
    plan(id, already, pl, pe, cl, ce, ul, ue);
    dom_id = ID_W'(id);
    start = 1;
    tick();
    start = 0;
    k = 0;
    while (exp_q.size() > 0) begin
      if (k == busy_at) begin start = 1; dom_id = 5'd30; end
      tick();
      if (k == busy_at) begin
        start = 0;
        // R11: the running sequence keeps its index
        check(pwr_id == ID_W'(id), "R11", "pwr_id", int'(pwr_id), id);
      end
      k++;
    end
    repeat (3) tick();
  endtask

  initial begin
    rst_n = 0; start = 0; dom_id = '0; pwr_state = '0;
    pwr_ack = 0; pwr_err = 0; clk_ack = 0; clk_err = 0; clamp_ack = 0; clamp_err = 0;
    p_lat = 0; c_lat = 0; u_lat = 0; p_e = 0; c_e = 0; u_e = 0;
    repeat (3) @(negedge clk);
    // R12: reset state is quiet
    check({dom_rst, clk_en, pwr_on, pwr_off, unclamp, done, err} == 7'b0, "R12",
          "reset outputs", int'({dom_rst, clk_en, done, err}), 0);
    rst_n = 1;
    repeat (4) tick();
    pwr_state[6] = 1'b1;
    run(3, 3, 0, 2, 0, 4, 0, -1);   // R2 R4 R5 success
    run(6, 0, 0, 1, 0, 1, 0, -1);   // R3 already powered
    run(25, 0, 0, 0, 0, 0, 0, -1);  // R9 index at the limit
    run(31, 0, 0, 0, 0, 0, 0, -1);  // R9 top of index range
    run(0, 2, 1, 0, 0, 0, 0, -1);   // R6 power error
    run(1, 0, 0, 0, 0, 0, 0, -1);   // R10 power timeout
    run(24, 1, 0, 3, 1, 0, 0, -1);  // R7 clock error
    run(2, 2, 0, 0, 0, 0, 0, -1);   // R10 clock timeout
    run(5, 1, 0, 1, 0, 2, 1, -1);   // R8 clamp error
    run(7, 1, 0, 2, 0, 0, 0, -1);   // R10 clamp timeout
    run(10, 2, 0, 2, 0, 3, 0, 5);   // R11 start while busy
    run(24, 1, 0, 1, 0, 1, 0, -1);  // R5 highest valid index
    summary();
  end

endmodule